// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address by walking a two-level page table held in physical memory. When a miss is accepted, the walker captures the virtual address and the root page number of the current address space. It then reads the first-level entry, which is selected by the top ten address bits. Next it reads the second-level entry, which is selected by the middle ten bits inside the page that the first entry names. Every table address is physical, so the walker's own reads need no translation.

The walker has one outcome per miss. A successful walk yields a refill record for the translation cache: the virtual page number, the physical page number and the permission bits. A walk that meets an entry whose present bit is clear, at either level, stops at once and signals a page fault. The fault carries the full virtual address and the level that failed. The memory side is a single request channel and a single response channel, each with a valid/ready handshake, and the walker keeps one read in flight at a time.

Top module: `ptw_top`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, mem_rsp_ready, refill_valid and fault_valid are all 0.
- R2: A miss is accepted only on a cycle where miss_ready is 1, and miss_ready is 1 only while the walker is idle. The virtual address and root_ppn are sampled on the accepting cycle, so later changes to those inputs do not affect the walk.
- R3: On the cycle after acceptance the walker requests address {root_ppn, va[31:22], 2'b00}.
- R4: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid and its address stays unchanged on the next cycle.
- R5: After a present first-level entry E1, the second request goes to {E1[31:12], va[21:12], 2'b00}.
- R6: mem_rsp_ready is 1 only while a response is awaited, and it is never 1 in the same cycle as mem_req_valid.
- R7: Bit 0 of an entry is the present bit. A first-level entry with bit 0 clear leads, on the next cycle, to fault_valid with fault_level 0, and no second request is issued.
- R8: A second-level entry with bit 0 clear leads, on the next cycle, to fault_valid with fault_level 1.
- R9: A second-level entry with bit 0 set leads, on the next cycle, to refill_valid with refill_vpn = va[31:12], refill_ppn = E2[31:12] and refill_perm = E2[4:1]. In that field, bit 0 is read, bit 1 is write, bit 2 is dirty and bit 3 is user.
- R10: refill_valid and fault_valid are one-cycle pulses and are never both 1. During a fault pulse fault_vaddr equals the full accepted virtual address. On the cycle after either pulse the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and takes the miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| root_ppn | input | 20 | Physical page number of the first-level table |
| mem_req_valid | output | 1 | Entry read request is valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data is valid |
| mem_rsp_ready | output | 1 | Walker accepts the response |
| mem_rsp_data | input | 32 | Page table entry read from memory |
| refill_valid | output | 1 | One-cycle pulse carrying a finished translation |
| refill_vpn | output | 20 | Virtual page number of the translation |
| refill_ppn | output | 20 | Physical page number of the translation |
| refill_perm | output | 4 | {user, dirty, write, read} from the second entry |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Virtual address that faulted |
| fault_level | output | 1 | 0 if the first-level entry was absent, 1 for the second |

## Verification
Each output has a fixed lag after the input edge that causes it. The first request appears one cycle after the accepting edge. The wait state is entered one cycle after a request handshake. The refill or fault pulse is visible one cycle after the edge that accepts the deciding response, and the walker is idle one cycle after that. The bench drives each handshake at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge. It inserts a chosen number of request and response stall cycles between these steps, and checks the outputs that must hold steady in every stall cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PN_W   = VA_W - OFF_W;
    localparam int PTE_W  = 32;
    localparam int PERM_W = 4;
    localparam int FLAG_W = PERM_W + 1;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_REQ1,
        WALK_WAIT1,
        WALK_REQ2,
        WALK_WAIT2,
        WALK_DONE,
        WALK_FAULT
    } walk_st_e;

    typedef struct packed {
        logic user;
        logic dirty;
        logic wr;
        logic rd;
    } perm_t;

    function automatic logic [IDX_W-1:0] top_index(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] mid_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    // Entries are 4 bytes, so the index is scaled by four inside the table page.
    function automatic logic [VA_W-1:0] entry_addr(input logic [PN_W-1:0] pn,
                                                   input logic [IDX_W-1:0] idx);
        return {pn, idx, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    output logic             present,
    output perm_t            perm,
    output logic [PN_W-1:0]  pn
);
    logic unused_rsvd;

    assign present     = pte[0];
    assign perm        = perm_t'(pte[FLAG_W-1:1]);
    assign pn          = pte[PTE_W-1 -: PN_W];
    assign unused_rsvd = ^pte[PTE_W-PN_W-1:FLAG_W];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic miss_valid,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic rsp_present,
    output logic miss_ready,
    output logic req_valid,
    output logic rsp_ready,
    output logic done_pulse,
    output logic fault_pulse,
    output logic fault_lvl,
    output logic sel_second,
    output logic take_miss,
    output logic take_first,
    output logic take_second
);
    walk_st_e st_q, st_d;
    logic     lvl_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WALK_IDLE:  if (miss_valid) st_d = WALK_REQ1;
            WALK_REQ1:  if (req_ready)  st_d = WALK_WAIT1;
            WALK_WAIT1: if (rsp_valid)  st_d = rsp_present ? WALK_REQ2 : WALK_FAULT;
            WALK_REQ2:  if (req_ready)  st_d = WALK_WAIT2;
            WALK_WAIT2: if (rsp_valid)  st_d = rsp_present ? WALK_DONE : WALK_FAULT;
            WALK_DONE:  st_d = WALK_IDLE;
            WALK_FAULT: st_d = WALK_IDLE;
            default:    st_d = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WALK_IDLE;
            lvl_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take_first)  lvl_q <= 1'b0;
            if (take_second) lvl_q <= 1'b1;
        end
    end

    assign miss_ready  = (st_q == WALK_IDLE);
    assign req_valid   = (st_q == WALK_REQ1) || (st_q == WALK_REQ2);
    assign rsp_ready   = (st_q == WALK_WAIT1) || (st_q == WALK_WAIT2);
    assign done_pulse  = (st_q == WALK_DONE);
    assign fault_pulse = (st_q == WALK_FAULT);
    assign fault_lvl   = lvl_q;
    assign sel_second  = (st_q == WALK_REQ2);
    assign take_miss   = miss_ready && miss_valid;
    assign take_first  = (st_q == WALK_WAIT1) && rsp_valid;
    assign take_second = (st_q == WALK_WAIT2) && rsp_valid;
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_miss,
    input  logic             take_first,
    input  logic             take_second,
    input  logic             sel_second,
    input  logic [VA_W-1:0]  miss_vaddr,
    input  logic [PN_W-1:0]  root_ppn,
    input  logic [PN_W-1:0]  rsp_pn,
    input  perm_t            rsp_perm,
    output logic [VA_W-1:0]  req_addr,
    output logic [VA_W-1:0]  walk_vaddr,
    output logic [PN_W-1:0]  leaf_pn,
    output perm_t            leaf_perm
);
    logic [VA_W-1:0] va_q;
    logic [PN_W-1:0] root_q;
    logic [PN_W-1:0] mid_pn_q;
    logic [PN_W-1:0] leaf_pn_q;
    perm_t           leaf_perm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q        <= '0;
            root_q      <= '0;
            mid_pn_q    <= '0;
            leaf_pn_q   <= '0;
            leaf_perm_q <= '0;
        end else begin
            if (take_miss) begin
                va_q   <= miss_vaddr;
                root_q <= root_ppn;
            end
            if (take_first) mid_pn_q <= rsp_pn;
            if (take_second) begin
                leaf_pn_q   <= rsp_pn;
                leaf_perm_q <= rsp_perm;
            end
        end
    end

    assign req_addr   = sel_second ? entry_addr(mid_pn_q, mid_index(va_q))
                                   : entry_addr(root_q, top_index(va_q));
    assign walk_vaddr = va_q;
    assign leaf_pn    = leaf_pn_q;
    assign leaf_perm  = leaf_perm_q;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [PN_W-1:0]   root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [VA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              refill_valid,
    output logic [PN_W-1:0]   refill_vpn,
    output logic [PN_W-1:0]   refill_ppn,
    output logic [PERM_W-1:0] refill_perm,
    output logic              fault_valid,
    output logic [VA_W-1:0]   fault_vaddr,
    output logic              fault_level
);
    logic            rsp_present;
    perm_t           rsp_perm;
    logic [PN_W-1:0] rsp_pn;
    logic            sel_second, take_miss, take_first, take_second;
    logic [VA_W-1:0] walk_vaddr;
    logic [PN_W-1:0] leaf_pn;
    perm_t           leaf_perm;

    ptw_pte_dec u_dec (
        .pte     (mem_rsp_data),
        .present (rsp_present),
        .perm    (rsp_perm),
        .pn      (rsp_pn)
    );

    ptw_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .miss_valid  (miss_valid),
        .req_ready   (mem_req_ready),
        .rsp_valid   (mem_rsp_valid),
        .rsp_present (rsp_present),
        .miss_ready  (miss_ready),
        .req_valid   (mem_req_valid),
        .rsp_ready   (mem_rsp_ready),
        .done_pulse  (refill_valid),
        .fault_pulse (fault_valid),
        .fault_lvl   (fault_level),
        .sel_second  (sel_second),
        .take_miss   (take_miss),
        .take_first  (take_first),
        .take_second (take_second)
    );

    ptw_datapath u_dp (
        .clk         (clk),
        .rst         (rst),
        .take_miss   (take_miss),
        .take_first  (take_first),
        .take_second (take_second),
        .sel_second  (sel_second),
        .miss_vaddr  (miss_vaddr),
        .root_ppn    (root_ppn),
        .rsp_pn      (rsp_pn),
        .rsp_perm    (rsp_perm),
        .req_addr    (mem_req_addr),
        .walk_vaddr  (walk_vaddr),
        .leaf_pn     (leaf_pn),
        .leaf_perm   (leaf_perm)
    );

    assign refill_vpn  = walk_vaddr[VA_W-1:OFF_W];
    assign refill_ppn  = leaf_pn;
    assign refill_perm = leaf_perm;
    assign fault_vaddr = walk_vaddr;
endmodule

// File: rtl/ptw_check.sv
module ptw_check (
    input logic        clk,
    input logic        rst,
    input logic        miss_valid,
    input logic        miss_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_ready,
    input logic        refill_valid,
    input logic        fault_valid
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R6
    rsp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_ready |-> !mem_req_valid);

    // R10
    refill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        refill_valid |=> (!refill_valid && miss_ready));

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> (!fault_valid && miss_ready));

    // R10
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (miss_ready && !mem_req_valid && !refill_valid && !fault_valid));
endmodule

bind ptw_top ptw_check u_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_ready (mem_rsp_ready),
    .refill_valid  (refill_valid),
    .fault_valid   (fault_valid)
);

// File: tb/ptw_top_test.sv
module ptw_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [19:0] root_ppn = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn;
    logic [19:0] refill_ppn;
    logic [3:0]  refill_perm;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_level;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ptw_top uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vaddr(miss_vaddr), .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn),
        .refill_ppn(refill_ppn), .refill_perm(refill_perm),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr),
        .fault_level(fault_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " miss_ready"}, 32'(miss_ready), 32'd1);
        chk({tag, " req_valid"}, 32'(mem_req_valid), 32'd0);
        chk({tag, " rsp_ready"}, 32'(mem_rsp_ready), 32'd0);
        chk({tag, " refill_valid"}, 32'(refill_valid), 32'd0);
        chk({tag, " fault_valid"}, 32'(fault_valid), 32'd0);
    endtask

    // Serve one request with a number of stall cycles; expected address from the bench.
    task automatic serve_req(input string tag, input logic [31:0] exp_addr, input int stall);
        for (int k = 0; k < stall; k++) begin
            chk({tag, " R4 valid held"}, 32'(mem_req_valid), 32'd1);
            chk({tag, " R4 addr held"}, mem_req_addr, exp_addr);
            chk("R2 busy during walk", 32'(miss_ready), 32'd0);
            chk("R6 no rsp_ready while requesting", 32'(mem_rsp_ready), 32'd0);
            @(negedge clk);
        end
        chk({tag, " valid"}, 32'(mem_req_valid), 32'd1);
        chk({tag, " addr"}, mem_req_addr, exp_addr);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
    endtask

    task automatic serve_rsp(input logic [31:0] data, input int stall);
        miss_valid = 1'b0;
        for (int k = 0; k < stall; k++) begin
            chk("R6 rsp_ready while waiting", 32'(mem_rsp_ready), 32'd1);
            chk("R6 no request while waiting", 32'(mem_req_valid), 32'd0);
            @(negedge clk);
        end
        chk("R6 rsp_ready at response", 32'(mem_rsp_ready), 32'd1);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = data;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
    endtask

    task automatic walk(input int i);
        logic [31:0] va, pte1, pte2;
        logic [19:0] root;
        logic        p1, p2;
        int          rq, rs;
        va   = {10'((i * 7 + 3) & 10'h3ff), 10'((i * 13 + i / 3) & 10'h3ff), 12'((i * 91) & 12'hfff)};
        root = 20'(32'h1_0000 + i * 5);
        p1   = (i % 5) != 1;
        p2   = (i % 7) != 2;
        pte1 = {20'(32'h2_0000 + i * 3), 7'(i * 11), 4'(i * 3), p1};
        pte2 = {20'(32'h8_0000 + i * 17), 7'(i * 5), 4'(i ^ (i >> 4)), p2};
        rq   = i % 3;
        rs   = (i / 3) % 3;

        chk("R2 ready when idle", 32'(miss_ready), 32'd1);
        miss_valid = 1'b1;
        miss_vaddr = va;
        root_ppn   = root;
        @(negedge clk);
        // Junk on the miss inputs after acceptance must not change the walk (R2).
        miss_vaddr = ~va;
        root_ppn   = ~root;
        serve_req("R3 first read", {root, va[31:22], 2'b00}, rq);
        serve_rsp(pte1, rs);
        if (!p1) begin
            chk("R7 fault_valid", 32'(fault_valid), 32'd1);
            chk("R7 fault_level", 32'(fault_level), 32'd0);
            chk("R7 no second request", 32'(mem_req_valid), 32'd0);
            chk("R10 fault_vaddr", fault_vaddr, va);
            chk("R10 no refill with fault", 32'(refill_valid), 32'd0);
        end else begin
            serve_req("R5 second read", {pte1[31:12], va[21:12], 2'b00}, (rq + 1) % 3);
            serve_rsp(pte2, (rs + 2) % 3);
            if (!p2) begin
                chk("R8 fault_valid", 32'(fault_valid), 32'd1);
                chk("R8 fault_level", 32'(fault_level), 32'd1);
                chk("R10 fault_vaddr", fault_vaddr, va);
                chk("R10 no refill with fault", 32'(refill_valid), 32'd0);
            end else begin
                chk("R9 refill_valid", 32'(refill_valid), 32'd1);
                chk("R9 refill_vpn", 32'(refill_vpn), 32'(va[31:12]));
                chk("R9 refill_ppn", 32'(refill_ppn), 32'(pte2[31:12]));
                chk("R9 refill_perm", 32'(refill_perm), 32'(pte2[4:1]));
                chk("R10 no fault with refill", 32'(fault_valid), 32'd0);
            end
        end
        @(negedge clk);
        check_idle("R10 idle after outcome");
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset state");
        for (int i = 0; i < 140; i++) begin
            walk(i);
        end
        // Reset during a walk returns to idle (R1).
        miss_valid = 1'b1;
        miss_vaddr = 32'h1234_5678;
        root_ppn   = 20'h00ABC;
        @(negedge clk);
        miss_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R1 reset mid-walk");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule